// File: doc/BRIEF.md
# Backup Watchdog Timer with Keyed Service

This block is a watchdog peripheral that asks for a system reset when software stops servicing it. Software programs a 16-bit modulus and a control word, and the control word's enable bit starts the countdown. Software must then write a two-word key to the service register before the timeout runs out. If no valid key pair arrives in time, the block drives a one-cycle reset request. It then reloads and keeps counting.

The timeout is `(modulus + 1) * 4096 + 4` counter ticks. A tick comes on every clock, or on every second clock when the half-rate select input is high. Three control bits can freeze the count while the chip is in a stop, wait or doze low-power state. The modulus and control registers each take exactly one write after a power-on reset. A reset raised by the watchdog itself leaves them as they are, so software that starts the watchdog early in boot keeps that configuration for the rest of the session.

Two state machines do the work. The key tracker has the states KEY_IDLE and KEY_ARMED. A 0x5555 write moves it to KEY_ARMED from either state. A 0xAAAA write in KEY_ARMED reloads the counter and returns it to KEY_IDLE, and any other service write returns it to KEY_IDLE. The timebase has the states CNT_OFF, CNT_RUN and CNT_FIRE. It goes from CNT_OFF to CNT_RUN with a reload when the enable bit is set. It goes from CNT_RUN to CNT_FIRE on a tick with the count at zero, and from CNT_FIRE back to CNT_RUN after one cycle, with the reload already in place.

Top module: `wdt_backup`

## Requirements
- R1: After power-on reset, the control register (address 0) reads 0x0000, the modulus register (address 1) reads 0xFFFF, the counter view (address 2) reads 0x0000 and `reset_req` is low.
- R2: Control bit 0 enables counting. With bit 0 clear, `reset_req` never rises.
- R3: The enable write is captured at clock edge E. The first reset request is visible after edge E + T + 1, where T = (modulus + 1) * 4096 + 4 with one tick per clock.
- R4: A service write of 0x5555 followed by a service write of 0xAAAA reloads the counter. Idle cycles between the two writes are allowed. If the 0xAAAA write is captured at edge S, the next request is visible after edge S + T.
- R5: A 0xAAAA write that does not directly follow a 0x5555 service write does not reload the counter, and any other value between the two keys breaks the pair. A repeated 0x5555 re-arms the tracker.
- R6: The control and modulus registers each accept only their first write after power-on reset. Later writes leave the read-back value unchanged.
- R7: Control bit 4 freezes the count while `stop_mode` is high, bit 3 while `wait_mode` is high and bit 2 while `doze_mode` is high. Each frozen clock delays the request by one cycle. A mode input whose bit is clear has no effect.
- R8: With `half_rate_sel` high the counter ticks on every second clock, so the first request comes about 2T clocks after enable.
- R9: `reset_req` is a one-cycle pulse. The counter then reloads and runs on, so unserviced requests repeat every T clocks.
- R10: A watchdog request leaves the programmed configuration and the write locks intact. Only `por_n` restores the defaults and reopens the registers for writing.
- R11: Address 2 reads the counter bits above the 12-bit prescale field, so it shows 2 right after a reload with modulus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 modulus, 2 service |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 modulus, 2 counter view |
| rd_data | output | 16 | Combinational read data |
| stop_mode | input | 1 | Chip is in stop mode |
| wait_mode | input | 1 | Chip is in wait mode |
| doze_mode | input | 1 | Chip is in doze mode |
| half_rate_sel | input | 1 | Counter ticks on every second clock |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Some properties are checked on every cycle by the assertions. The request lasts exactly one cycle. A locked register never changes value. A frozen counter holds its count. A valid key pair returns the tracker to KEY_IDLE, and the cycle after it carries no request. The scenarios alone can show the exact timeout length, the extra cycle of the CNT_OFF to CNT_RUN start, broken and restarted key pairs, the repeat period, the freeze delay for each mode bit, the half-rate window, and that only a power-on reset clears the configuration.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MOD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SVC = 2'd2;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_DOZE_BIT = 2;
    localparam int CTL_WAIT_BIT = 3;
    localparam int CTL_STOP_BIT = 4;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_e;

    typedef enum logic [1:0] {
        CNT_OFF,
        CNT_RUN,
        CNT_FIRE
    } cnt_state_e;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import wdt_pkg::*;
#(
    parameter int MOD_W = 16,
    parameter logic [MOD_W-1:0] MOD_RESET = '1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctl_q,
    output logic [MOD_W-1:0]  mod_q
);
    logic ctl_lock_q;
    logic mod_lock_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q      <= '0;
            ctl_lock_q <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTL && !ctl_lock_q) begin
            ctl_q      <= wr_data;
            ctl_lock_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mod_q      <= MOD_RESET;
            mod_lock_q <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_MOD && !mod_lock_q) begin
            mod_q      <= wr_data[MOD_W-1:0];
            mod_lock_q <= 1'b1;
        end
    end

    // R6
    ctl_locked_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(ctl_lock_q) |-> $stable(ctl_q));
    // R6
    mod_locked_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(mod_lock_q) |-> $stable(mod_q));
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              svc_ok
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        svc_ok  = 1'b0;
        if (svc_wr) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (svc_data == KEY_FIRST) state_d = KEY_ARMED;
                end
                KEY_ARMED: begin
                    if (svc_data == KEY_FIRST) begin
                        state_d = KEY_ARMED;
                    end else if (svc_data == KEY_SECOND) begin
                        state_d = KEY_IDLE;
                        svc_ok  = 1'b1;
                    end else begin
                        state_d = KEY_IDLE;
                    end
                end
                default: state_d = KEY_IDLE;
            endcase
        end
    end

    // R5
    key_pair_done_chk: assert property (@(posedge clk) disable iff (!por_n)
        svc_ok |=> state_q == KEY_IDLE);
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
    import wdt_pkg::*;
#(
    parameter int MOD_W      = 16,
    parameter int PRE_LOG2   = 12,
    parameter int TAIL_TICKS = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic [MOD_W-1:0] modulus,
    input  logic             freeze,
    input  logic             half_rate,
    input  logic             svc_ok,
    output logic             reset_req,
    output logic [MOD_W-1:0] cnt_view
);
    localparam int CNT_W     = MOD_W + PRE_LOG2 + 1;
    localparam int PRESCALE  = 1 << PRE_LOG2;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;
    logic             phase_q;
    logic             advance;

    assign load_val = (CNT_W'(modulus) + CNT_W'(1)) * CNT_W'(PRESCALE)
                      + CNT_W'(TAIL_TICKS) - CNT_W'(1);
    assign advance  = (!half_rate || phase_q) && !freeze;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= CNT_OFF;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            phase_q <= !phase_q;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CNT_OFF: begin
                if (en) begin
                    state_d = CNT_RUN;
                    cnt_d   = load_val;
                end
            end
            CNT_RUN: begin
                if (svc_ok) begin
                    cnt_d = load_val;
                end else if (advance) begin
                    if (cnt_q == '0) begin
                        state_d = CNT_FIRE;
                        cnt_d   = load_val;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            CNT_FIRE: begin
                state_d = en ? CNT_RUN : CNT_OFF;
                if (svc_ok)       cnt_d = load_val;
                else if (advance) cnt_d = cnt_q - CNT_W'(1);
            end
            default: state_d = CNT_OFF;
        endcase
    end

    always_comb begin
        reset_req = (state_q == CNT_FIRE);
        cnt_view  = cnt_q[PRE_LOG2 +: MOD_W];
    end

    // R9
    req_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        reset_req |=> !reset_req);
    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == CNT_RUN && freeze && !svc_ok) |=> $stable(cnt_q));
    // R4
    svc_no_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        svc_ok |=> !reset_req);
    // R2
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!por_n)
        reset_req |-> $past(en));
endmodule

// File: rtl/wdt_backup.sv
module wdt_backup
    import wdt_pkg::*;
#(
    parameter int MOD_W      = 16,
    parameter int PRE_LOG2   = 12,
    parameter int TAIL_TICKS = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [15:0]       rd_data,
    input  logic              stop_mode,
    input  logic              wait_mode,
    input  logic              doze_mode,
    input  logic              half_rate_sel,
    output logic              reset_req
);
    logic [DATA_W-1:0] ctl_q;
    logic [MOD_W-1:0]  mod_q;
    logic [MOD_W-1:0]  cnt_view;
    logic              svc_ok;
    logic              freeze;

    wdt_cfg_regs #(.MOD_W(MOD_W)) cfg_i (
        .clk    (clk),
        .por_n  (por_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .ctl_q  (ctl_q),
        .mod_q  (mod_q)
    );

    wdt_key_seq key_i (
        .clk     (clk),
        .por_n   (por_n),
        .svc_wr  (wr_en && wr_addr == ADDR_SVC),
        .svc_data(wr_data),
        .svc_ok  (svc_ok)
    );

    assign freeze = (stop_mode && ctl_q[CTL_STOP_BIT])
                  || (wait_mode && ctl_q[CTL_WAIT_BIT])
                  || (doze_mode && ctl_q[CTL_DOZE_BIT]);

    wdt_timebase #(
        .MOD_W     (MOD_W),
        .PRE_LOG2  (PRE_LOG2),
        .TAIL_TICKS(TAIL_TICKS)
    ) tb_i (
        .clk      (clk),
        .por_n    (por_n),
        .en       (ctl_q[CTL_EN_BIT]),
        .modulus  (mod_q),
        .freeze   (freeze),
        .half_rate(half_rate_sel),
        .svc_ok   (svc_ok),
        .reset_req(reset_req),
        .cnt_view (cnt_view)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_CTL: rd_data = ctl_q;
            ADDR_MOD: rd_data = DATA_W'(mod_q);
            ADDR_SVC: rd_data = DATA_W'(cnt_view);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: tb/wdt_backup_tb_top.sv
module wdt_backup_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        stop_mode = 1'b0;
    logic        wait_mode = 1'b0;
    logic        doze_mode = 1'b0;
    logic        half_rate_sel = 1'b0;
    logic        reset_req;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int exp_q[$];
    int got_q[$];

    localparam int T0 = 1 * 4096 + 4;
    localparam int T1 = 2 * 4096 + 4;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_backup dut_i (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .stop_mode(stop_mode), .wait_mode(wait_mode), .doze_mode(doze_mode),
        .half_rate_sel(half_rate_sel), .reset_req(reset_req)
    );

    // monitor: records the cycle of every visible request
    always @(negedge clk) if (por_n && reset_req) got_q.push_back(cyc);

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drain(input string tag);
        chk({tag, " pulse count"}, got_q.size(), exp_q.size());
        while (exp_q.size() > 0 && got_q.size() > 0)
            chk({tag, " pulse cycle"}, got_q.pop_front(), exp_q.pop_front());
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, output int e);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        e = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic por();
        @(negedge clk);
        por_n = 1'b0;
        stop_mode = 1'b0; wait_mode = 1'b0; doze_mode = 1'b0; half_rate_sel = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog timeout actual=%0d expected=finish", cyc);
        summary();
        $finish;
    end

    initial begin
        int e, s, v, first;
        // R1 reset state
        por();
        rd(2'd0, v); chk("R1 ctl reset", v, 0);
        rd(2'd1, v); chk("R1 mod reset", v, 16'hFFFF);
        rd(2'd2, v); chk("R1 view reset", v, 0);
        chk("R1 req low", int'(reset_req), 0);

        // R2 / R6: disabled, then locked
        wr(2'd1, 16'h0000, e);
        wr(2'd0, 16'h0000, e);
        wr(2'd0, 16'h0001, e);
        wr(2'd1, 16'h0005, e);
        rd(2'd0, v); chk("R6 ctl second write ignored", v, 0);
        rd(2'd1, v); chk("R6 mod second write ignored", v, 0);
        wait_until(e + T0 + 1000);
        drain("R2 disabled");

        // R3 / R9 / R11 / R10
        por();
        wr(2'd1, 16'h0001, e);
        wr(2'd0, 16'h0001, e);
        exp_q.push_back(e + T1 + 1);
        exp_q.push_back(e + 2 * T1 + 1);
        wait_until(e + 1);
        rd(2'd2, v); chk("R11 view after load", v, 2);
        wait_until(e + 1 + 4096);
        rd(2'd2, v); chk("R11 view after 4096 ticks", v, 1);
        wait_until(e + 2 * T1 + 20);
        drain("R3 R9 periodic");
        wr(2'd1, 16'h0005, s);
        rd(2'd0, v); chk("R10 ctl kept after request", v, 1);
        rd(2'd1, v); chk("R10 mod kept and locked", v, 1);
        por();
        rd(2'd0, v); chk("R10 ctl cleared by por", v, 0);
        rd(2'd1, v); chk("R10 mod cleared by por", v, 16'hFFFF);

        // R4 valid service
        por();
        wr(2'd1, 16'h0001, e);
        wr(2'd0, 16'h0001, e);
        wait_until(e + 3000);
        wr(2'd2, 16'h5555, s);
        wr(2'd2, 16'hAAAA, s);
        rd(2'd2, v); chk("R4 view after service", v, 2);
        exp_q.push_back(s + T1);
        wait_until(s + T1 + 20);
        drain("R4 service");

        // R5 broken and restarted keys
        por();
        wr(2'd1, 16'h0000, e);
        wr(2'd0, 16'h0001, e);
        wait_until(e + 1000);
        wr(2'd2, 16'hAAAA, s);
        wr(2'd2, 16'h5555, s);
        wr(2'd2, 16'h1234, s);
        wr(2'd2, 16'hAAAA, s);
        exp_q.push_back(e + T0 + 1);
        wait_until(e + 5000);
        wr(2'd2, 16'h5555, s);
        wr(2'd2, 16'h5555, s);
        wr(2'd2, 16'hAAAA, s);
        exp_q.push_back(s + T0);
        wait_until(s + T0 + 20);
        drain("R5 key order");

        // R7 wait bit only
        por();
        wr(2'd1, 16'h0000, e);
        wr(2'd0, 16'h0009, e);
        wait_until(e + 1000);
        stop_mode = 1'b1; doze_mode = 1'b1;
        repeat (300) @(negedge clk);
        stop_mode = 1'b0; doze_mode = 1'b0;
        wait_mode = 1'b1;
        repeat (500) @(negedge clk);
        wait_mode = 1'b0;
        exp_q.push_back(e + T0 + 1 + 500);
        wait_until(e + T0 + 600);
        drain("R7 wait freeze");

        // R7 stop and doze bits
        por();
        wr(2'd1, 16'h0000, e);
        wr(2'd0, 16'h0015, e);
        wait_until(e + 1000);
        wait_mode = 1'b1;
        repeat (200) @(negedge clk);
        wait_mode = 1'b0;
        stop_mode = 1'b1;
        repeat (300) @(negedge clk);
        stop_mode = 1'b0;
        doze_mode = 1'b1;
        repeat (100) @(negedge clk);
        doze_mode = 1'b0;
        exp_q.push_back(e + T0 + 1 + 400);
        wait_until(e + T0 + 500);
        drain("R7 stop doze freeze");

        // R8 half rate
        por();
        half_rate_sel = 1'b1;
        wr(2'd1, 16'h0000, e);
        wr(2'd0, 16'h0001, e);
        wait_until(e + 2 * T0 + 10);
        chk("R8 half-rate pulse count", got_q.size(), 1);
        first = (got_q.size() > 0) ? got_q[0] : 0;
        chk("R8 pulse not early", int'(first >= e + 2 * T0 - 2), 1);
        chk("R8 pulse not late", int'(first <= e + 2 * T0 + 4), 1);
        got_q.delete();

        summary();
        $finish;
    end
endmodule